// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps a DDR2 SDRAM refreshed on behalf of the main command engine. A down-counter, reloaded from a rate value that may be changed at any time, marks each refresh as due. Due refreshes are held in a small saturating backlog, so none is lost while the command arbiter is busy with other traffic. For each refresh the block asks the arbiter for the command bus. Once granted, it closes every bank with a precharge-all command, waits out the row-precharge time and issues an auto-refresh command. It then waits out the refresh recovery time and hands the bus back with a one-cycle done pulse.

The same sequencer also takes the memory into and out of self-refresh under control of a request input. On entry it precharges all banks, then issues the refresh command with the clock enable low. It holds the device there until the request drops. On exit it raises the clock enable and waits out the recovery time before it releases the bus. A precharge-all is also issued once after every reset, with no refresh after it.

Top module: `sdram_refresh_sched`

## Requirements
- R1: With the arbiter always granting, successive auto-refresh commands are spaced exactly refresh_rate+1 cycles apart.
- R2: The rate value is sampled only when the interval counter reloads. A change takes effect after the count in progress: the interval that is running keeps its old length, and the one after it uses the new value.
- R3: Every auto-refresh command is preceded by a precharge-all command. The refresh follows the precharge by max(t_rp,1)+1 cycles.
- R4: Commands appear on cmd_rcw as {RAS_n,CAS_n,WE_n}: precharge-all = 3'b010, refresh = 3'b001, NOP = 3'b111. Only these three codes are used. addr_a10 is 1 exactly in precharge-all cycles.
- R5: During and after reset the outputs read NOP, addr_a10=0, cke=1, busy=0 and bus_req=0. The first command after reset is a precharge-all that is not followed by a refresh, and it appears within 4 cycles of reset release when granted.
- R6: Due refreshes accumulate in a backlog that saturates at 8. After a long wait without grant, exactly 8 refreshes are issued, each with its own precharge-all.
- R7: The block issues no command until arb_grant has been sampled high while bus_req is high. bus_req stays high while the grant is withheld.
- R8: busy (and bus_req) stays high from the request until max(t_rfc,1) cycles after the refresh command. In the following cycle busy is low and seq_done is high for exactly one cycle.
- R9: While self_refresh_req is held, the block precharges all banks and then issues the refresh code with cke low. cke then stays low, with NOP on the command bus and busy high.
- R10: When self_refresh_req drops, cke returns high and busy falls max(t_rfc,1)+1 cycles later. Refresh ticks that occur during the self-refresh episode are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_rate | input | RATE_W | Interval reload value (period = value+1 cycles) |
| t_rp | input | TIME_W | Wait cycles after precharge-all |
| t_rfc | input | TIME_W | Wait cycles after refresh or self-refresh exit |
| self_refresh_req | input | 1 | Hold high to keep the memory in self-refresh |
| arb_grant | input | 1 | Command bus granted by the arbiter |
| bus_req | output | 1 | Request for the command bus |
| cmd_rcw | output | 3 | Command code {RAS_n,CAS_n,WE_n} |
| addr_a10 | output | 1 | Address bit 10 (all-bank select) |
| cke | output | 1 | Clock enable to the memory |
| busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | One-cycle pulse when the bus is released |

## Verification
The bench measures exact cycle spacings for four rate and timing sets: precharge to refresh, refresh to release, and refresh to refresh. An off-by-one in the reload or in a wait counter shifts one of these counts. It changes the rate in the middle of an interval; a counter that reloads continuously instead of at zero produces a short interval one period too early. It withholds the grant long enough for more than 8 ticks to occur, so that a backlog that wraps or fails to saturate issues the wrong number of refreshes. It also holds self-refresh across several ticks and then checks that no refreshes are replayed after exit, and that cke and busy fall and rise in the required cycles.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

  // {RAS_n, CAS_n, WE_n}
  typedef enum logic [2:0] {
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    JOB_INIT,
    JOB_REF,
    JOB_SR
  } job_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_PRE,
    ST_WRP,
    ST_REF,
    ST_WRFC,
    ST_SRE,
    ST_SRH,
    ST_SRX,
    ST_DONE
  } st_e;

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [RATE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= rate;
    else if (cnt_q == '0) cnt_q <= rate;
    else                  cnt_q <= cnt_q - 1'b1;
  end

  always_comb tick = !rst && (cnt_q == '0);
endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic discard,
  input  logic take,
  output logic pending
);
  localparam int CW = $clog2(MAX_PEND + 1);
  localparam logic [CW-1:0] MAXV = CW'(MAX_PEND);

  logic [CW-1:0] cnt_q;
  logic inc, dec;

  always_comb begin
    inc = tick && !discard && (cnt_q != MAXV);
    dec = take && (cnt_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else begin
      case ({inc, dec})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_comb pending = (cnt_q != '0);
endmodule

// File: rtl/refresh_seq_fsm.sv
module refresh_seq_fsm
  import sdram_refresh_pkg::*;
#(
  parameter int TIME_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pending,
  input  logic              sr_req,
  input  logic              grant,
  input  logic [TIME_W-1:0] t_rp,
  input  logic [TIME_W-1:0] t_rfc,
  output logic              bus_req,
  output logic [2:0]        cmd,
  output logic              a10,
  output logic              cke,
  output logic              busy,
  output logic              done,
  output logic              take,
  output logic              sr_window
);
  st_e               st_q, st_n;
  job_e              job_q, job_n;
  logic              init_q, init_n;
  logic [TIME_W-1:0] wcnt_q, wcnt_n;
  logic              wait_last;

  always_comb wait_last = (wcnt_q <= TIME_W'(1));

  always_comb begin
    st_n   = st_q;
    job_n  = job_q;
    init_n = init_q;
    wcnt_n = wcnt_q;
    case (st_q)
      ST_IDLE: begin
        if (init_q) begin
          job_n = JOB_INIT; init_n = 1'b0; st_n = ST_REQ;
        end else if (pending) begin
          job_n = JOB_REF; st_n = ST_REQ;
        end else if (sr_req) begin
          job_n = JOB_SR; st_n = ST_REQ;
        end
      end
      ST_REQ:  if (grant) st_n = ST_PRE;
      ST_PRE:  begin st_n = ST_WRP; wcnt_n = t_rp; end
      ST_WRP: begin
        if (wait_last) begin
          case (job_q)
            JOB_INIT: st_n = ST_DONE;
            JOB_REF:  st_n = ST_REF;
            default:  st_n = ST_SRE;
          endcase
        end else wcnt_n = wcnt_q - 1'b1;
      end
      ST_REF:  begin st_n = ST_WRFC; wcnt_n = t_rfc; end
      ST_WRFC: begin
        if (wait_last) st_n = ST_DONE;
        else wcnt_n = wcnt_q - 1'b1;
      end
      ST_SRE:  st_n = ST_SRH;
      ST_SRH:  if (!sr_req) st_n = ST_SRX;
      ST_SRX:  begin st_n = ST_WRFC; wcnt_n = t_rfc; end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      job_q   <= JOB_INIT;
      init_q  <= 1'b1;
      wcnt_q  <= '0;
      bus_req <= 1'b0;
      busy    <= 1'b0;
      cmd     <= CMD_NOP;
      a10     <= 1'b0;
      cke     <= 1'b1;
      done    <= 1'b0;
    end else begin
      st_q    <= st_n;
      job_q   <= job_n;
      init_q  <= init_n;
      wcnt_q  <= wcnt_n;
      bus_req <= (st_n != ST_IDLE) && (st_n != ST_DONE);
      busy    <= (st_n != ST_IDLE) && (st_n != ST_DONE);
      cmd     <= (st_n == ST_PRE) ? CMD_PRE :
                 ((st_n == ST_REF) || (st_n == ST_SRE)) ? CMD_REF : CMD_NOP;
      a10     <= (st_n == ST_PRE);
      cke     <= !((st_n == ST_SRE) || (st_n == ST_SRH));
      done    <= (st_n == ST_DONE);
    end
  end

  always_comb begin
    take      = (st_q == ST_WRP) && wait_last && (job_q == JOB_REF);
    sr_window = (job_q == JOB_SR) && (st_q != ST_IDLE);
  end
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int RATE_W   = 16,
  parameter int TIME_W   = 5,
  parameter int MAX_PEND = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] refresh_rate,
  input  logic [TIME_W-1:0] t_rp,
  input  logic [TIME_W-1:0] t_rfc,
  input  logic              self_refresh_req,
  input  logic              arb_grant,
  output logic              bus_req,
  output logic [2:0]        cmd_rcw,
  output logic              addr_a10,
  output logic              cke,
  output logic              busy,
  output logic              seq_done
);
  logic tick, pending, take, sr_window;

  refresh_interval_timer #(.RATE_W(RATE_W)) u_timer (
    .clk(clk), .rst(rst), .rate(refresh_rate), .tick(tick)
  );

  refresh_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
    .clk(clk), .rst(rst), .tick(tick), .discard(sr_window),
    .take(take), .pending(pending)
  );

  refresh_seq_fsm #(.TIME_W(TIME_W)) u_fsm (
    .clk(clk), .rst(rst), .pending(pending), .sr_req(self_refresh_req),
    .grant(arb_grant), .t_rp(t_rp), .t_rfc(t_rfc), .bus_req(bus_req),
    .cmd(cmd_rcw), .a10(addr_a10), .cke(cke), .busy(busy),
    .done(seq_done), .take(take), .sr_window(sr_window)
  );
endmodule

// File: rtl/sdram_refresh_checks.sv
module sdram_refresh_checks
  import sdram_refresh_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       arb_grant,
  input logic       bus_req,
  input logic [2:0] cmd_rcw,
  input logic       addr_a10,
  input logic       cke,
  input logic       busy,
  input logic       seq_done
);
  logic pre_seen_q;

  always_ff @(posedge clk) begin
    if (rst)                    pre_seen_q <= 1'b0;
    else if (cmd_rcw == CMD_PRE) pre_seen_q <= 1'b1;
    else if (cmd_rcw == CMD_REF) pre_seen_q <= 1'b0;
  end

  AST_REF_NEEDS_PRE: assert property (@(posedge clk) disable iff (rst)
    (cmd_rcw == CMD_REF) |-> pre_seen_q); // R3
  AST_PRE_DRIVES_A10: assert property (@(posedge clk) disable iff (rst)
    (cmd_rcw == CMD_PRE) |-> addr_a10); // R4
  AST_A10_ONLY_PRE: assert property (@(posedge clk) disable iff (rst)
    addr_a10 |-> (cmd_rcw == CMD_PRE)); // R4
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (cmd_rcw == CMD_PRE) || (cmd_rcw == CMD_REF) || (cmd_rcw == CMD_NOP)); // R4
  AST_PRE_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    (cmd_rcw == CMD_PRE) |-> ($past(arb_grant) && $past(bus_req))); // R7
  AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmd_rcw != CMD_NOP) |-> busy); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done); // R8
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> !busy); // R8
  AST_SR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!cke && $past(!cke)) |-> (cmd_rcw == CMD_NOP)); // R9
endmodule

bind sdram_refresh_sched sdram_refresh_checks u_checks (
  .clk(clk), .rst(rst), .arb_grant(arb_grant), .bus_req(bus_req),
  .cmd_rcw(cmd_rcw), .addr_a10(addr_a10), .cke(cke), .busy(busy),
  .seq_done(seq_done)
);

// File: tb/sdram_refresh_sched_test.sv
module sdram_refresh_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] C_PRE = 3'b010;
  localparam logic [2:0] C_REF = 3'b001;
  localparam logic [2:0] C_NOP = 3'b111;

  // rate, t_rp, t_rfc, ref-to-ref, pre-to-ref, ref-to-release
  localparam int NV = 4;
  localparam int VEC [0:NV-1][0:5] = '{
    '{40, 2, 5, 41, 3,  6},
    '{25, 1, 3, 26, 2,  4},
    '{60, 0, 0, 61, 2,  2},
    '{33, 4, 9, 34, 5, 10}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] refresh_rate = 16'd40;
  logic [4:0]  t_rp = 5'd2, t_rfc = 5'd5;
  logic self_refresh_req = 1'b0, arb_grant = 1'b1;
  logic bus_req, addr_a10, cke, busy, seq_done;
  logic [2:0] cmd_rcw;

  int cyc = 0, checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_refresh_sched uut (
    .clk(clk), .rst(rst), .refresh_rate(refresh_rate), .t_rp(t_rp),
    .t_rfc(t_rfc), .self_refresh_req(self_refresh_req), .arb_grant(arb_grant),
    .bus_req(bus_req), .cmd_rcw(cmd_rcw), .addr_a10(addr_a10), .cke(cke),
    .busy(busy), .seq_done(seq_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic wait_cmd(input logic [2:0] code, output int t);
    int n = 0;
    do begin @(negedge clk); n++; end while (cmd_rcw != code && n < 3000);
    t = cyc;
    if (n >= 3000) check(1'b0, "wait_cmd timeout", n, 0);
  endtask

  task automatic run_until_idle(output int t, output int refs);
    int n = 0;
    refs = 0;
    do begin
      @(negedge clk); n++;
      if (cmd_rcw == C_REF) refs++;
    end while (busy && n < 3000);
    t = cyc;
  endtask

  task automatic do_reset(input int rate, input int rp, input int rfc,
                          input logic g, input logic sr);
    @(negedge clk);
    rst = 1'b1; refresh_rate = 16'(rate); t_rp = 5'(rp); t_rfc = 5'(rfc);
    arb_grant = g; self_refresh_req = sr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int t0, t1, t2, t3, refs, pres;
    bit bad;

    // R5: reset state
    do_reset(40, 2, 5, 1'b1, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check(cmd_rcw == C_NOP && !addr_a10 && cke && !busy && !bus_req,
          "R5 reset outputs", {cmd_rcw, addr_a10, cke, busy, bus_req},
          {C_NOP, 4'b0100});

    // Vector table: R1, R3, R4, R5, R8
    for (int i = 0; i < NV; i++) begin
      do_reset(VEC[i][0], VEC[i][1], VEC[i][2], 1'b1, 1'b0);
      t0 = cyc;
      wait_cmd(C_PRE, t1);
      check(t1 - t0 <= 4, "R5 first precharge", t1 - t0, 4);
      check(addr_a10 == 1'b1, "R4 a10 on precharge", addr_a10, 1);
      run_until_idle(t2, refs);
      check(refs == 0, "R5 init has no refresh", refs, 0);
      wait_cmd(C_PRE, t1);
      wait_cmd(C_REF, t2);
      check(t2 - t1 == VEC[i][4], "R3 pre-to-ref", t2 - t1, VEC[i][4]);
      run_until_idle(t3, refs);
      check(t3 - t2 == VEC[i][5], "R8 ref-to-release", t3 - t2, VEC[i][5]);
      check(seq_done == 1'b1, "R8 done pulse", seq_done, 1);
      @(negedge clk);
      check(seq_done == 1'b0 && cmd_rcw == C_NOP, "R4 idle NOP", cmd_rcw, C_NOP);
      wait_cmd(C_REF, t3);
      check(t3 - t2 == VEC[i][3], "R1 refresh period", t3 - t2, VEC[i][3]);
    end

    // R2: live rate change takes effect after current count
    do_reset(40, 1, 1, 1'b1, 1'b0);
    wait_cmd(C_REF, t1);
    @(negedge clk);
    refresh_rate = 16'd20;
    wait_cmd(C_REF, t2);
    check(t2 - t1 == 41, "R2 running interval kept", t2 - t1, 41);
    wait_cmd(C_REF, t3);
    check(t3 - t2 == 21, "R2 new interval", t3 - t2, 21);

    // R6, R7: grant withheld, backlog saturates at 8
    do_reset(4, 1, 1, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    bad = 1'b0;
    for (int k = 0; k < 80; k++) begin
      if (cmd_rcw != C_NOP || !bus_req || !busy) bad = 1'b1;
      @(negedge clk);
    end
    check(!bad, "R7 no command without grant", bad, 0);
    refresh_rate = 16'd1000;
    repeat (10) @(negedge clk);
    arb_grant = 1'b1;
    refs = 0; pres = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (cmd_rcw == C_REF) refs++;
      if (cmd_rcw == C_PRE) pres++;
    end
    check(refs == 8, "R6 saturated backlog refreshes", refs, 8);
    check(pres == 9, "R6 precharge per refresh plus init", pres, 9);
    check(!busy, "R6 drained", busy, 0);

    // R9, R10: self-refresh
    do_reset(30, 2, 3, 1'b1, 1'b1);
    t0 = 0;
    do begin @(negedge clk); t0++; end while (cke && t0 < 500);
    check(!cke && cmd_rcw == C_REF, "R9 entry command with cke low", cmd_rcw, C_REF);
    refresh_rate = 16'd1000;
    bad = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (cke || cmd_rcw != C_NOP || !busy) bad = 1'b1;
    end
    check(!bad, "R9 held in self-refresh", bad, 0);
    self_refresh_req = 1'b0;
    t0 = 0;
    do begin @(negedge clk); t0++; end while (!cke && t0 < 50);
    t1 = cyc;
    check(cke && busy, "R10 cke high on exit", cke, 1);
    run_until_idle(t2, refs);
    check(t2 - t1 == 4, "R10 exit recovery", t2 - t1, 4);
    refs = 0;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (cmd_rcw == C_REF) refs++;
    end
    check(refs == 0, "R10 ticks in self-refresh discarded", refs, 0);

    finish_run();
  end
endmodule